// File: doc/BRIEF.md
# Instruction Breakpoint Return-Address Capture

This unit sits beside a simple in-order pipeline and watches its execute stage. Each cycle the pipeline presents the instruction it is about to complete: its address, whether it is a delayed branch, whether it occupies a delay slot, and the branch target that applies to it. The unit compares these addresses, and separately the addresses of data-memory accesses, against one programmed break address under a per-bit mask. On a hit it raises a one-cycle break request and captures the return address that the exception entry sequence will later push on the stack.

Three break modes exist. In the pre-execution fetch mode the hit instruction is squashed through an inhibit output and its own address is captured, unless it sits in a delay slot, in which case it completes and the branch target is captured. In the post-execution fetch mode the hit instruction completes and the address of whatever would run next is captured. A delayed branch and its slot are never split. In the data mode the break is taken only after a parameterised number of further instructions have completed, so the captured address is flagged as imprecise.

The captured address stays valid until the exception logic acknowledges it. While a request is outstanding, or while a deferred break is still being counted out, further hits are ignored.

Top module: `ibrk_pc_capture`

## Requirements
- R1: After reset, brk_req and brk_pending are 0 and ex_inhibit is 0.
- R2: An address hits when every bit not set in cfg_mask equals the same bit of cfg_addr; a 1 in cfg_mask excludes that bit. With cfg_en at 0, or cfg_mode at 2'b11, nothing breaks.
- R3: Mode 2'b00 (pre-execution fetch), hit on an instruction with ex_slot at 0: ex_inhibit is 1 in that cycle, brk_req is 1 in the next cycle, brk_pc equals the hit address, and brk_imprecise is 0.
- R4: Mode 2'b00, hit on an instruction with ex_slot at 1: ex_inhibit stays 0 and brk_pc equals ex_target of that instruction.
- R5: Mode 2'b01 (post-execution fetch), hit on an instruction that is neither a delayed branch nor in a slot: ex_inhibit stays 0, brk_req is 1 in the next cycle and brk_pc equals the hit address plus 2.
- R6: Mode 2'b01, hit on a delayed branch: no request until the next valid instruction (its slot) completes, then brk_req is 1 in the following cycle with brk_pc equal to the branch's ex_target.
- R7: Mode 2'b01, hit on an instruction with ex_slot at 1: brk_pc equals its ex_target.
- R8: Mode 2'b10 (data access): a hit on dacc_addr while dacc_valid is 1 starts a count of DATA_LAT (default 2) completed instructions, counting only those in later cycles. After the last one completes, the break is taken with brk_imprecise at 1 and brk_pc equal to that instruction's address plus 2. If that instruction is a delayed branch, the break waits for its slot and brk_pc is the branch target. If it is in a slot, brk_pc is its ex_target.
- R9: brk_req is high for exactly one cycle. brk_pc and brk_pending hold until brk_ack is sampled high.
- R10: While brk_pending is 1, hits raise neither ex_inhibit nor brk_req. This includes a hit in the same cycle as brk_ack.
- R11: brk_ack while nothing is pending has no effect: brk_pending stays 0 and no request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Break enable |
| cfg_mode | input | 2 | 00 pre-fetch, 01 post-fetch, 10 data, 11 none |
| cfg_addr | input | 32 | Break address |
| cfg_mask | input | 32 | Per-bit compare exclusion (1 = ignore bit) |
| ex_valid | input | 1 | An instruction completes (or is squashed) this cycle |
| ex_pc | input | 32 | Address of that instruction |
| ex_dbranch | input | 1 | Instruction is a delayed branch |
| ex_slot | input | 1 | Instruction sits in a delay slot |
| ex_target | input | 32 | Branch target of the branch or of the slot's branch |
| dacc_valid | input | 1 | Data access cycle this cycle |
| dacc_addr | input | 32 | Data access address |
| brk_ack | input | 1 | Exception logic has consumed the captured address |
| ex_inhibit | output | 1 | Squash the current instruction (same cycle) |
| brk_req | output | 1 | One-cycle break request |
| brk_pc | output | 32 | Captured return address |
| brk_pending | output | 1 | Captured address valid, awaiting acknowledge |
| brk_imprecise | output | 1 | Break came from a data access |

## Verification
The acknowledge of an outstanding break and a fresh address hit can land in the same cycle. The bench provokes this by holding brk_ack high while presenting an instruction that matches in pre-execution mode. It judges the outcome at the ports. The inhibit must stay low in that cycle and no request may follow, pending must drop, and a later hit must again break normally. The counted data-break path and the deferred delayed-branch path are also driven with idle cycles placed inside them, to show that only valid instructions advance them.

// File: rtl/ibrk_pkg.sv
package ibrk_pkg;

    localparam int unsigned ADDR_W = 32;
    localparam int unsigned INSN_BYTES = 2;

    typedef enum logic [1:0] {
        MODE_FETCH_PRE  = 2'b00,
        MODE_FETCH_POST = 2'b01,
        MODE_DATA       = 2'b10,
        MODE_NONE       = 2'b11
    } brk_mode_e;

    typedef enum logic [1:0] {
        SQ_IDLE      = 2'b00,
        SQ_SLOT_WAIT = 2'b01,
        SQ_COUNT     = 2'b10
    } seq_state_e;

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] pc;
        logic              dbranch;
        logic              slot;
        logic [ADDR_W-1:0] target;
    } ex_info_t;

    typedef struct packed {
        logic              fire;
        logic [ADDR_W-1:0] pc;
        logic              imprecise;
    } trig_t;

    function automatic logic [ADDR_W-1:0] next_seq(input logic [ADDR_W-1:0] pc);
        return pc + ADDR_W'(INSN_BYTES);
    endfunction

endpackage

// File: rtl/ibrk_addr_match.sv
module ibrk_addr_match #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] addr,
    input  logic [W-1:0] ref_addr,
    input  logic [W-1:0] mask,
    output logic         hit
);
    logic [W-1:0] bit_ok;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign bit_ok[i] = mask[i] | ~(addr[i] ^ ref_addr[i]);
    end

    assign hit = &bit_ok;
endmodule

// File: rtl/ibrk_seq.sv
module ibrk_seq
    import ibrk_pkg::*;
#(
    parameter int unsigned DATA_LAT = 2,
    localparam int unsigned CNT_W = $clog2(DATA_LAT + 1)
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      cfg_en,
    input  brk_mode_e cfg_mode,
    input  ex_info_t  ex,
    input  logic      fetch_hit,
    input  logic      data_hit,
    input  logic      dacc_valid,
    input  logic      pending,
    output logic      inhibit,
    output trig_t     trig
);
    seq_state_e        st, st_n;
    logic [CNT_W-1:0]  cnt, cnt_n;
    logic [ADDR_W-1:0] held_tgt, held_tgt_n;
    logic              held_imp, held_imp_n;

    // Decide, for the instruction in the execute stage, whether a break
    // is taken now, deferred to the slot, or counted out.
    always_comb begin
        st_n       = st;
        cnt_n      = cnt;
        held_tgt_n = held_tgt;
        held_imp_n = held_imp;
        inhibit    = 1'b0;
        trig       = '0;
        unique case (st)
            SQ_IDLE: begin
                if (cfg_en && !pending) begin
                    unique case (cfg_mode)
                        MODE_FETCH_PRE: begin
                            if (ex.valid && fetch_hit) begin
                                trig.fire = 1'b1;
                                if (ex.slot) begin
                                    trig.pc = ex.target;
                                end else begin
                                    trig.pc = ex.pc;
                                    inhibit = 1'b1;
                                end
                            end
                        end
                        MODE_FETCH_POST: begin
                            if (ex.valid && fetch_hit) begin
                                if (ex.slot) begin
                                    trig.fire = 1'b1;
                                    trig.pc   = ex.target;
                                end else if (ex.dbranch) begin
                                    st_n       = SQ_SLOT_WAIT;
                                    held_tgt_n = ex.target;
                                    held_imp_n = 1'b0;
                                end else begin
                                    trig.fire = 1'b1;
                                    trig.pc   = next_seq(ex.pc);
                                end
                            end
                        end
                        MODE_DATA: begin
                            if (dacc_valid && data_hit) begin
                                st_n  = SQ_COUNT;
                                cnt_n = CNT_W'(DATA_LAT);
                            end
                        end
                        default: ;
                    endcase
                end
            end
            SQ_SLOT_WAIT: begin
                if (ex.valid) begin
                    trig.fire      = 1'b1;
                    trig.pc        = held_tgt;
                    trig.imprecise = held_imp;
                    st_n           = SQ_IDLE;
                end
            end
            SQ_COUNT: begin
                if (ex.valid) begin
                    if (cnt == CNT_W'(1)) begin
                        if (ex.slot) begin
                            trig.fire      = 1'b1;
                            trig.pc        = ex.target;
                            trig.imprecise = 1'b1;
                            st_n           = SQ_IDLE;
                        end else if (ex.dbranch) begin
                            st_n       = SQ_SLOT_WAIT;
                            held_tgt_n = ex.target;
                            held_imp_n = 1'b1;
                        end else begin
                            trig.fire      = 1'b1;
                            trig.pc        = next_seq(ex.pc);
                            trig.imprecise = 1'b1;
                            st_n           = SQ_IDLE;
                        end
                    end else begin
                        cnt_n = cnt - CNT_W'(1);
                    end
                end
            end
            default: st_n = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= SQ_IDLE;
            cnt      <= '0;
            held_tgt <= '0;
            held_imp <= 1'b0;
        end else begin
            st       <= st_n;
            cnt      <= cnt_n;
            held_tgt <= held_tgt_n;
            held_imp <= held_imp_n;
        end
    end
endmodule

// File: rtl/ibrk_capture.sv
module ibrk_capture
    import ibrk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  trig_t             trig,
    input  logic              ack,
    output logic              req,
    output logic [ADDR_W-1:0] pc,
    output logic              pending,
    output logic              imprecise
);
    always_ff @(posedge clk) begin
        if (rst) begin
            req       <= 1'b0;
            pc        <= '0;
            pending   <= 1'b0;
            imprecise <= 1'b0;
        end else begin
            req <= trig.fire;
            if (trig.fire) begin
                pending   <= 1'b1;
                pc        <= trig.pc;
                imprecise <= trig.imprecise;
            end else if (ack) begin
                pending <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/ibrk_pc_capture.sv
module ibrk_pc_capture
    import ibrk_pkg::*;
#(
    parameter int unsigned DATA_LAT = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_en,
    input  logic [1:0]  cfg_mode,
    input  logic [31:0] cfg_addr,
    input  logic [31:0] cfg_mask,
    input  logic        ex_valid,
    input  logic [31:0] ex_pc,
    input  logic        ex_dbranch,
    input  logic        ex_slot,
    input  logic [31:0] ex_target,
    input  logic        dacc_valid,
    input  logic [31:0] dacc_addr,
    input  logic        brk_ack,
    output logic        ex_inhibit,
    output logic        brk_req,
    output logic [31:0] brk_pc,
    output logic        brk_pending,
    output logic        brk_imprecise
);
    ex_info_t ex;
    trig_t    trig;
    logic     fetch_hit;
    logic     data_hit;

    assign ex = '{valid: ex_valid, pc: ex_pc, dbranch: ex_dbranch,
                  slot: ex_slot, target: ex_target};

    ibrk_addr_match #(.W(ADDR_W)) fetch_cmp_i (
        .addr(ex_pc), .ref_addr(cfg_addr), .mask(cfg_mask), .hit(fetch_hit)
    );

    ibrk_addr_match #(.W(ADDR_W)) data_cmp_i (
        .addr(dacc_addr), .ref_addr(cfg_addr), .mask(cfg_mask), .hit(data_hit)
    );

    ibrk_seq #(.DATA_LAT(DATA_LAT)) seq_i (
        .clk(clk), .rst(rst), .cfg_en(cfg_en),
        .cfg_mode(brk_mode_e'(cfg_mode)), .ex(ex),
        .fetch_hit(fetch_hit), .data_hit(data_hit), .dacc_valid(dacc_valid),
        .pending(brk_pending), .inhibit(ex_inhibit), .trig(trig)
    );

    ibrk_capture cap_i (
        .clk(clk), .rst(rst), .trig(trig), .ack(brk_ack),
        .req(brk_req), .pc(brk_pc), .pending(brk_pending),
        .imprecise(brk_imprecise)
    );
endmodule

// File: rtl/ibrk_pc_capture_chk.sv
module ibrk_pc_capture_chk (
    input logic        clk,
    input logic        rst,
    input logic        cfg_en,
    input logic [1:0]  cfg_mode,
    input logic        ex_valid,
    input logic [31:0] ex_pc,
    input logic        ex_slot,
    input logic        brk_ack,
    input logic        ex_inhibit,
    input logic        brk_req,
    input logic [31:0] brk_pc,
    input logic        brk_pending,
    input logic        brk_imprecise
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!brk_req && !brk_pending));

    // R3
    inhibit_cause_chk: assert property (@(posedge clk) disable iff (rst)
        ex_inhibit |-> (ex_valid && cfg_en && cfg_mode == 2'b00 && !ex_slot && !brk_pending));

    // R3
    inhibit_capture_chk: assert property (@(posedge clk) disable iff (rst)
        ex_inhibit |=> (brk_req && brk_pc == $past(ex_pc) && !brk_imprecise));

    // R9
    req_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        brk_req |=> !brk_req);

    // R9
    pc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (brk_pending && !brk_ack) |=> (brk_pending && $stable(brk_pc)));

    // R10
    busy_block_chk: assert property (@(posedge clk) disable iff (rst)
        brk_pending |=> !brk_req);

    // R11
    pending_rise_chk: assert property (@(posedge clk) disable iff (rst)
        !brk_pending |=> (!brk_pending || brk_req));
endmodule

bind ibrk_pc_capture ibrk_pc_capture_chk chk_i (
    .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_mode(cfg_mode),
    .ex_valid(ex_valid), .ex_pc(ex_pc), .ex_slot(ex_slot),
    .brk_ack(brk_ack), .ex_inhibit(ex_inhibit), .brk_req(brk_req),
    .brk_pc(brk_pc), .brk_pending(brk_pending), .brk_imprecise(brk_imprecise)
);

// File: tb/ibrk_pc_capture_tb.sv
module ibrk_pc_capture_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_en;
    logic [1:0]  cfg_mode;
    logic [31:0] cfg_addr, cfg_mask;
    logic        ex_valid, ex_dbranch, ex_slot;
    logic [31:0] ex_pc, ex_target;
    logic        dacc_valid;
    logic [31:0] dacc_addr;
    logic        brk_ack;
    logic        ex_inhibit, brk_req, brk_pending, brk_imprecise;
    logic [31:0] brk_pc;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    logic seen_inh;

    always #2 clk = ~clk;

    ibrk_pc_capture dut_i (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle_in();
        ex_valid = 0; ex_pc = '0; ex_dbranch = 0; ex_slot = 0; ex_target = '0;
        dacc_valid = 0; dacc_addr = '0; brk_ack = 0;
    endtask

    // one cycle: drive, sample inhibit mid-cycle, then pass the edge
    task automatic cyc(input logic v, input logic [31:0] pc, input logic db,
                       input logic sl, input logic [31:0] tgt,
                       input logic dv, input logic [31:0] da, input logic ack);
        ex_valid = v; ex_pc = pc; ex_dbranch = db; ex_slot = sl; ex_target = tgt;
        dacc_valid = dv; dacc_addr = da; brk_ack = ack;
        #1 seen_inh = ex_inhibit;
        @(posedge clk); #1;
        idle_in();
    endtask

    task automatic insn(input logic [31:0] pc, input logic db, input logic sl, input logic [31:0] tgt);
        cyc(1, pc, db, sl, tgt, 0, '0, 0);
    endtask

    task automatic ack_it();
        cyc(0, '0, 0, 0, '0, 0, '0, 1);
    endtask

    task automatic setup(input logic en, input logic [1:0] m, input logic [31:0] a, input logic [31:0] msk);
        cfg_en = en; cfg_mode = m; cfg_addr = a; cfg_mask = msk;
    endtask

    task automatic t_reset();
        chk("R1 req", brk_req, 0);
        chk("R1 pending", brk_pending, 0);
        chk("R1 inhibit", ex_inhibit, 0);
    endtask

    task automatic t_before_plain();
        setup(1, 2'b00, 32'h1000, 32'h0);
        insn(32'h0FFE, 0, 0, '0);
        chk("R2 miss inh", seen_inh, 0);
        chk("R2 miss req", brk_req, 0);
        insn(32'h1000, 0, 0, '0);
        chk("R3 inh", seen_inh, 1);
        chk("R3 req", brk_req, 1);
        chk("R3 pc", brk_pc, 32'h1000);
        chk("R3 precise", brk_imprecise, 0);
        insn(32'h1000, 0, 0, '0);
        chk("R10 no inh while pending", seen_inh, 0);
        chk("R9 pulse", brk_req, 0);
        chk("R9 pending held", brk_pending, 1);
        chk("R9 pc held", brk_pc, 32'h1000);
        ack_it();
        chk("R9 ack clears", brk_pending, 0);
    endtask

    task automatic t_mask();
        setup(1, 2'b00, 32'h2000, 32'h0000_000F);
        insn(32'h200A, 0, 0, '0);
        chk("R2 masked hit", brk_req, 1);
        chk("R2 masked pc", brk_pc, 32'h200A);
        ack_it();
        insn(32'h2010, 0, 0, '0);
        chk("R2 unmasked bit differs", brk_req, 0);
        setup(0, 2'b00, 32'h2000, 32'h0);
        insn(32'h2000, 0, 0, '0);
        chk("R2 disabled", {seen_inh, brk_req}, 2'b00);
        setup(1, 2'b11, 32'h2000, 32'h0);
        insn(32'h2000, 0, 0, '0);
        chk("R2 mode none", {seen_inh, brk_req}, 2'b00);
    endtask

    task automatic t_before_slot();
        setup(1, 2'b00, 32'h3002, 32'h0);
        insn(32'h3000, 1, 0, 32'h4000);
        chk("R4 branch no req", brk_req, 0);
        insn(32'h3002, 0, 1, 32'h4000);
        chk("R4 slot not inhibited", seen_inh, 0);
        chk("R4 req", brk_req, 1);
        chk("R4 pc target", brk_pc, 32'h4000);
        ack_it();
    endtask

    task automatic t_after();
        setup(1, 2'b01, 32'h5000, 32'h0);
        insn(32'h5000, 0, 0, '0);
        chk("R5 no inh", seen_inh, 0);
        chk("R5 req", brk_req, 1);
        chk("R5 pc next", brk_pc, 32'h5002);
        ack_it();
        setup(1, 2'b01, 32'h6000, 32'h0);
        insn(32'h6000, 1, 0, 32'h7000);
        chk("R6 held at branch", brk_req, 0);
        cyc(0, '0, 0, 0, '0, 0, '0, 0);
        chk("R6 held over bubble", brk_req, 0);
        insn(32'h6002, 0, 1, 32'h7000);
        chk("R6 req after slot", brk_req, 1);
        chk("R6 pc target", brk_pc, 32'h7000);
        ack_it();
        setup(1, 2'b01, 32'h6002, 32'h0);
        insn(32'h6000, 1, 0, 32'h7100);
        insn(32'h6002, 0, 1, 32'h7100);
        chk("R7 req", brk_req, 1);
        chk("R7 pc target", brk_pc, 32'h7100);
        ack_it();
    endtask

    task automatic t_data();
        setup(1, 2'b10, 32'h8000, 32'h0);
        insn(32'h8000, 0, 0, '0);
        chk("R8 fetch ignored in data mode", brk_req, 0);
        cyc(1, 32'h0FE, 0, 0, '0, 1, 32'h8000, 0);
        chk("R8 no req at access", brk_req, 0);
        insn(32'h100, 0, 0, '0);
        chk("R8 first retire", brk_req, 0);
        cyc(0, '0, 0, 0, '0, 0, '0, 0);
        insn(32'h102, 0, 0, '0);
        chk("R8 req", brk_req, 1);
        chk("R8 pc", brk_pc, 32'h104);
        chk("R8 imprecise", brk_imprecise, 1);
        ack_it();
        cyc(0, '0, 0, 0, '0, 1, 32'h8000, 0);
        insn(32'h200, 0, 0, '0);
        insn(32'h202, 1, 0, 32'h900);
        chk("R8 branch held", brk_req, 0);
        insn(32'h204, 0, 1, 32'h900);
        chk("R8 req after slot", brk_req, 1);
        chk("R8 branch pc", brk_pc, 32'h900);
        chk("R8 branch imprecise", brk_imprecise, 1);
        ack_it();
    endtask

    task automatic t_collide();
        setup(1, 2'b00, 32'hA000, 32'h0);
        insn(32'hA000, 0, 0, '0);
        chk("R10 setup req", brk_req, 1);
        cyc(1, 32'hA000, 0, 0, '0, 0, '0, 1);
        chk("R10 no inh with ack", seen_inh, 0);
        chk("R10 no req with ack", brk_req, 0);
        chk("R10 pending cleared", brk_pending, 0);
        insn(32'hA000, 0, 0, '0);
        chk("R10 breaks again", brk_req, 1);
        ack_it();
        ack_it();
        chk("R11 stray ack pending", brk_pending, 0);
        chk("R11 stray ack req", brk_req, 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #400000;
        checks++; errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
        finish_run();
    end

    initial begin
        idle_in();
        setup(0, 2'b11, '0, '0);
        rst = 1;
        repeat (3) @(posedge clk);
        #1 rst = 0;
        t_reset();
        t_before_plain();
        t_mask();
        t_before_slot();
        t_after();
        t_data();
        t_collide();
        finish_run();
    end
endmodule